// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers many peripheral interrupt lines onto one CPU interrupt pin through two register levels. A secondary level takes 32 peripheral sources and holds its own mask and status registers. Its enabled sources fold into three group summary bits. Those summary bits occupy fixed positions of a 32-bit primary status word. The primary word also carries direct sources. Some direct sources are level-sensitive. Others are captured on a rising edge into a latch register and stay set until software clears them.

Software reaches the mask, status, latch and software-interrupt registers over a simple synchronous register bus. The block raises one interrupt output whenever an enabled primary bit is pending. It also offers a pending vector. The vector names the lowest enabled primary source. When that source is a group summary, the vector points into the secondary level instead, so a handler can dispatch without a second lookup.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset the primary mask, latch register, software register, secondary mask and secondary edge latches are zero, irqOut and vecValid are low, and every register read returns zero while all inputs are low.
- R2: A primary bit that is neither an edge bit (16–19, 22–24, 28–30) nor a group bit (4, 5, 6) follows priIrqIn in the same cycle. irqOut is high exactly when any bit of (primary status AND primary mask) is set.
- R3: A rising edge on a primary edge bit sets that bit in the latch register (address 2) at the next clock edge. The bit stays set after the input falls.
- R4: A write to the latch register clears each latched bit written as 0 and leaves each bit written as 1 unchanged.
- R5: A rising edge that arrives in the same cycle as a write clearing that latch bit leaves the bit set.
- R6: The software register (address 3) keeps only bits 28–30 of a write, and those bits show as set in the primary status (address 1).
- R7: Primary bit 6 is the OR of (secondary status AND secondary mask) over secondary bits 0–7. Bit 5 is that OR over bits 8–15. Bit 4 is that OR over bits 16–31.
- R8: Secondary bits 16, 22 and 28 latch on a rising edge and are cleared by writing the secondary status (address 5) with that bit at 0; a 1 leaves them unchanged. Other secondary bits follow secIrqIn. The secondary mask is at address 4.
- R9: vecValid equals irqOut. When it is high and the lowest pending enabled primary bit is not a group bit, vecIdx is that bit's index.
- R10: When the lowest pending enabled primary bit is a group bit, vecIdx is 32 plus the lowest set bit of (secondary status AND secondary mask).
- R11: priIrqIn on the group positions 4–6 has no effect on status, irqOut or the vector. Writes to the read-only primary status address change nothing.
- R12: Read data (busRdata) is registered. It takes the selected register's value at the clock edge where busRd is high and holds it at all other edges. The primary mask is at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priIrqIn | input | 32 | Direct primary interrupt sources |
| secIrqIn | input | 32 | Secondary peripheral interrupt sources |
| busWr | input | 1 | One-cycle write strobe |
| busRd | input | 1 | One-cycle read strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| irqOut | output | 1 | Combined interrupt to the CPU |
| vecValid | output | 1 | High when an enabled source is pending |
| vecIdx | output | 6 | Index of the pending source to service |

## Verification
The bench builds the block with its default parameters. These are 32 primary and 32 secondary bits, the standard edge sets, group positions 4, 5 and 6, and software bits 28–30. With these values all three groups can be driven. So can the mix of edge and level bits in both levels, and vector values above 32 from the redirect. The widths are large enough to place a pending group bit below a pending direct bit. That makes the lowest-index choice and the redirect show up together. Races between a new edge and an AND-style clear are driven on purpose.

// File: rtl/cic_pkg.sv
package cic_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_PRI_MASK = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRI_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LATCH    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_SOFT     = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SEC_MASK = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_SEC_STAT = 3'd5;

  typedef struct packed {
    logic              wrPriMask;
    logic              wrLatch;
    logic              wrSoft;
    logic              wrSecMask;
    logic              wrSecStat;
    logic              rdEn;
    logic [ADDR_W-1:0] rdSel;
  } cic_strobe_t;

endpackage

// File: rtl/cic_ffs.sv
module cic_ffs #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
(
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output cic_strobe_t       st
);
  always_comb begin
    st           = '0;
    st.wrPriMask = busWr && (busAddr == ADDR_PRI_MASK);
    st.wrLatch   = busWr && (busAddr == ADDR_LATCH);
    st.wrSoft    = busWr && (busAddr == ADDR_SOFT);
    st.wrSecMask = busWr && (busAddr == ADDR_SEC_MASK);
    st.wrSecStat = busWr && (busAddr == ADDR_SEC_STAT);
    st.rdEn      = busRd;
    st.rdSel     = busAddr;
  end
endmodule

// File: rtl/cic_datapath.sv
module cic_datapath
  import cic_pkg::*;
#(
  parameter int              PRI_W         = 32,
  parameter int              SEC_W         = 32,
  parameter int              DATA_W        = 32,
  parameter logic [PRI_W-1:0] PRI_EDGE_MASK = 32'h71CF_0000,
  parameter logic [PRI_W-1:0] SOFT_MASK     = 32'h7000_0000,
  parameter logic [SEC_W-1:0] SEC_EDGE_MASK = 32'h1041_0000,
  parameter int              SUPER_BIT     = 4,
  parameter int              MISC_BIT      = 5,
  parameter int              AUDIO_BIT     = 6,
  parameter int              AUDIO_LO      = 0,
  parameter int              AUDIO_HI      = 7,
  parameter int              MISC_LO       = 8,
  parameter int              MISC_HI       = 15,
  parameter int              SUPER_LO      = 16,
  parameter int              SUPER_HI      = 31,
  parameter int              VEC_W         = $clog2(PRI_W + SEC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cic_strobe_t       st,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PRI_W-1:0]  priIrqIn,
  input  logic [SEC_W-1:0]  secIrqIn,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecIdx,
  output logic [PRI_W-1:0]  latchOut
);
  localparam int PIW   = $clog2(PRI_W);
  localparam int SIW   = $clog2(SEC_W);
  localparam int GRP_N = 3;

  function automatic logic [SEC_W-1:0] rangeMask(input int lo, input int hi);
    logic [SEC_W-1:0] m;
    m = '0;
    for (int i = 0; i < SEC_W; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam int               GRP_BIT  [GRP_N] = '{SUPER_BIT, MISC_BIT, AUDIO_BIT};
  localparam logic [SEC_W-1:0] GRP_MASK [GRP_N] = '{rangeMask(SUPER_LO, SUPER_HI),
                                                   rangeMask(MISC_LO, MISC_HI),
                                                   rangeMask(AUDIO_LO, AUDIO_HI)};
  localparam logic [PRI_W-1:0] GROUP_POS = (PRI_W'(1) << SUPER_BIT) |
                                           (PRI_W'(1) << MISC_BIT) |
                                           (PRI_W'(1) << AUDIO_BIT);
  localparam logic [PRI_W-1:0] LEVEL_MASK = ~(PRI_EDGE_MASK | GROUP_POS);

  logic [PRI_W-1:0] priMask, priLatch, priSoft, priPrev;
  logic [SEC_W-1:0] secMask, secLatch, secPrev;
  logic [PRI_W-1:0] priRise, priStatus, priPend;
  logic [SEC_W-1:0] secRise, secStatus, secPend;
  logic [GRP_N-1:0] groupSum;

  // edge detection against the previous sampled input
  assign priRise = priIrqIn & ~priPrev & PRI_EDGE_MASK;
  assign secRise = secIrqIn & ~secPrev & SEC_EDGE_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priPrev  <= '0;
      secPrev  <= '0;
      priMask  <= '0;
      priLatch <= '0;
      priSoft  <= '0;
      secMask  <= '0;
      secLatch <= '0;
    end else begin
      priPrev <= priIrqIn & PRI_EDGE_MASK;
      secPrev <= secIrqIn & SEC_EDGE_MASK;
      if (st.wrPriMask) priMask <= wdata[PRI_W-1:0];
      if (st.wrSecMask) secMask <= wdata[SEC_W-1:0];
      if (st.wrSoft)    priSoft <= wdata[PRI_W-1:0] & SOFT_MASK;
      // AND-style clear; a fresh edge in the same cycle is kept
      priLatch <= (st.wrLatch   ? (priLatch & wdata[PRI_W-1:0]) : priLatch) | priRise;
      secLatch <= (st.wrSecStat ? (secLatch & wdata[SEC_W-1:0]) : secLatch) | secRise;
    end
  end

  assign secStatus = (secIrqIn & ~SEC_EDGE_MASK) | secLatch;
  assign secPend   = secStatus & secMask;

  for (genvar g = 0; g < GRP_N; g++) begin : g_group
    assign groupSum[g] = |(secPend & GRP_MASK[g]);
  end

  always_comb begin
    priStatus = (priIrqIn & LEVEL_MASK) | priLatch | priSoft;
    for (int g = 0; g < GRP_N; g++) begin
      priStatus[GRP_BIT[g]] = groupSum[g];
    end
  end

  assign priPend = priStatus & priMask;
  assign irqOut  = |priPend;

  logic           priFound, secFound;
  logic [PIW-1:0] priIdx;
  logic [SIW-1:0] secIdx;

  cic_ffs #(.W(PRI_W), .IW(PIW)) u_priFfs (.vec(priPend), .found(priFound), .idx(priIdx));
  cic_ffs #(.W(SEC_W), .IW(SIW)) u_secFfs (.vec(secPend), .found(secFound), .idx(secIdx));

  logic isGroup;
  assign isGroup  = GROUP_POS[priIdx] && secFound;
  assign vecValid = priFound;
  assign vecIdx   = isGroup ? (VEC_W'(PRI_W) + VEC_W'(secIdx)) : VEC_W'(priIdx);

  logic [DATA_W-1:0] rdNext;
  always_comb begin
    case (st.rdSel)
      ADDR_PRI_MASK: rdNext = DATA_W'(priMask);
      ADDR_PRI_STAT: rdNext = DATA_W'(priStatus);
      ADDR_LATCH:    rdNext = DATA_W'(priLatch);
      ADDR_SOFT:     rdNext = DATA_W'(priSoft);
      ADDR_SEC_MASK: rdNext = DATA_W'(secMask);
      ADDR_SEC_STAT: rdNext = DATA_W'(secStatus);
      default:       rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata <= '0;
    else if (st.rdEn) rdata <= rdNext;
  end

  assign latchOut = priLatch;
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cic_pkg::*;
#(
  parameter int              PRI_W         = 32,
  parameter int              SEC_W         = 32,
  parameter int              DATA_W        = 32,
  parameter logic [PRI_W-1:0] PRI_EDGE_MASK = 32'h71CF_0000,
  parameter logic [PRI_W-1:0] SOFT_MASK     = 32'h7000_0000,
  parameter logic [SEC_W-1:0] SEC_EDGE_MASK = 32'h1041_0000,
  parameter int              SUPER_BIT     = 4,
  parameter int              MISC_BIT      = 5,
  parameter int              AUDIO_BIT     = 6,
  parameter int              VEC_W         = $clog2(PRI_W + SEC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRI_W-1:0]  priIrqIn,
  input  logic [SEC_W-1:0]  secIrqIn,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecIdx
);
  cic_strobe_t      st;
  logic [PRI_W-1:0] priLatchQ;

  cic_ctrl u_ctrl (.busWr(busWr), .busRd(busRd), .busAddr(busAddr), .st(st));

  cic_datapath #(
    .PRI_W(PRI_W), .SEC_W(SEC_W), .DATA_W(DATA_W),
    .PRI_EDGE_MASK(PRI_EDGE_MASK), .SOFT_MASK(SOFT_MASK), .SEC_EDGE_MASK(SEC_EDGE_MASK),
    .SUPER_BIT(SUPER_BIT), .MISC_BIT(MISC_BIT), .AUDIO_BIT(AUDIO_BIT), .VEC_W(VEC_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .wdata(busWdata),
    .priIrqIn(priIrqIn), .secIrqIn(secIrqIn), .rdata(busRdata),
    .irqOut(irqOut), .vecValid(vecValid), .vecIdx(vecIdx), .latchOut(priLatchQ)
  );
endmodule

// File: rtl/cic_checker.sv
module cic_checker
  import cic_pkg::*;
#(
  parameter int              PRI_W         = 32,
  parameter int              DATA_W        = 32,
  parameter logic [PRI_W-1:0] PRI_EDGE_MASK = 32'h71CF_0000,
  parameter int              SUPER_BIT     = 4,
  parameter int              MISC_BIT      = 5,
  parameter int              AUDIO_BIT     = 6,
  parameter int              VEC_W         = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PRI_W-1:0]  priIrqIn,
  input logic              busWr,
  input logic              busRd,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut,
  input logic              vecValid,
  input logic [VEC_W-1:0]  vecIdx,
  input logic [PRI_W-1:0]  priLatch
);
  logic [PRI_W-1:0] seenIn;
  logic [PRI_W-1:0] riseSeen;

  always_ff @(posedge clk) begin
    if (!rst_n) seenIn <= '0;
    else        seenIn <= priIrqIn;
  end
  assign riseSeen = priIrqIn & ~seenIn & PRI_EDGE_MASK;

  // R3 / R5: every observed rising edge ends up latched
  a_r3_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((priLatch & $past(riseSeen)) == $past(riseSeen)));

  // R4: latched bits only fall after a latch-register write
  a_r4_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(priLatch) & ~priLatch)) |-> $past(busWr && (busAddr == ADDR_LATCH)));

  // R9: valid flag tracks the interrupt output
  a_r9_valid_is_irq: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid == irqOut);

  // R10: a vector below the primary width never names a group bit
  a_r10_no_group_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && (vecIdx < VEC_W'(PRI_W))) |->
      ((vecIdx != VEC_W'(SUPER_BIT)) && (vecIdx != VEC_W'(MISC_BIT)) && (vecIdx != VEC_W'(AUDIO_BIT))));

  // R12: read data only moves after a read strobe
  a_r12_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busRd) |-> $stable(busRdata));
endmodule

bind cascade_irq_ctrl cic_checker #(
  .PRI_W(PRI_W), .DATA_W(DATA_W), .PRI_EDGE_MASK(PRI_EDGE_MASK),
  .SUPER_BIT(SUPER_BIT), .MISC_BIT(MISC_BIT), .AUDIO_BIT(AUDIO_BIT), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .priIrqIn(priIrqIn), .busWr(busWr), .busRd(busRd),
  .busAddr(busAddr), .busRdata(busRdata), .irqOut(irqOut), .vecValid(vecValid),
  .vecIdx(vecIdx), .priLatch(priLatchQ)
);

// File: tb/sim_cascade_irq_ctrl.sv
`timescale 1ns/1ps
module sim_cascade_irq_ctrl;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] priIrqIn = '0;
  logic [31:0] secIrqIn = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, vecValid;
  logic [5:0]  vecIdx;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(HALF) clk = ~clk;

  cascade_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .priIrqIn(priIrqIn), .secIrqIn(secIrqIn),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .vecValid(vecValid), .vecIdx(vecIdx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; priIrqIn = '0; secIrqIn = '0; busWr = 1'b0; busRd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic pulsePri(input int b);
    @(negedge clk); priIrqIn[b] = 1'b1;
    @(negedge clk); priIrqIn[b] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    doReset();
    #1;
    chk("R1 irqOut", {31'b0, irqOut}, 32'h0);
    chk("R1 vecValid", {31'b0, vecValid}, 32'h0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 read zero", d, 32'h0);
    end
  endtask

  task automatic t_level();
    logic [31:0] d;
    doReset();
    wr(3'd0, 32'h0010_0004);
    @(negedge clk); priIrqIn[20] = 1'b1; #1;
    chk("R2 irq on level", {31'b0, irqOut}, 32'h1);
    chk("R9 vec 20", {26'b0, vecIdx}, 32'd20);
    rd(3'd1, d);
    chk("R2 status level", d, 32'h0010_0000);
    @(negedge clk); priIrqIn[2] = 1'b1; #1;
    chk("R9 lowest wins", {26'b0, vecIdx}, 32'd2);
    @(negedge clk); priIrqIn = '0; #1;
    chk("R2 irq drops", {31'b0, irqOut}, 32'h0);
    chk("R9 valid low", {31'b0, vecValid}, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    doReset();
    wr(3'd0, 32'h0002_0000);
    pulsePri(17);
    #1;
    chk("R3 irq held", {31'b0, irqOut}, 32'h1);
    rd(3'd2, d);
    chk("R3 latch bit", d, 32'h0002_0000);
    rd(3'd1, d);
    chk("R3 status bit", d, 32'h0002_0000);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    doReset();
    pulsePri(16);
    pulsePri(17);
    wr(3'd2, ~32'h0001_0000);
    rd(3'd2, d);
    chk("R4 zero clears", d, 32'h0002_0000);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d);
    chk("R4 one keeps", d, 32'h0002_0000);
    wr(3'd2, 32'h0);
    rd(3'd2, d);
    chk("R4 all cleared", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    doReset();
    pulsePri(18);
    @(negedge clk);
    priIrqIn[19] = 1'b1;
    busWr = 1'b1; busAddr = 3'd2; busWdata = 32'h0;
    @(negedge clk);
    busWr = 1'b0; priIrqIn[19] = 1'b0;
    rd(3'd2, d);
    chk("R5 edge beats clear", d, 32'h0008_0000);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    doReset();
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d);
    chk("R6 soft bits kept", d, 32'h7000_0000);
    rd(3'd1, d);
    chk("R6 soft in status", d, 32'h7000_0000);
    wr(3'd0, 32'h2000_0000);
    #1;
    chk("R6 soft vector", {26'b0, vecIdx}, 32'd29);
    wr(3'd3, 32'h0);
    #1;
    chk("R6 soft off", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_groups();
    logic [31:0] d;
    doReset();
    wr(3'd0, 32'h0000_0070);
    @(negedge clk); secIrqIn[3] = 1'b1; #1;
    chk("R7 unmasked sec quiet", {31'b0, irqOut}, 32'h0);
    wr(3'd4, 32'h0010_0208);
    #1;
    chk("R10 audio vec", {26'b0, vecIdx}, 32'd35);
    rd(3'd1, d);
    chk("R7 audio -> bit6", d, 32'h0000_0040);
    @(negedge clk); secIrqIn[9] = 1'b1;
    rd(3'd1, d);
    chk("R7 misc -> bit5", d, 32'h0000_0060);
    #1;
    chk("R10 lowest secondary", {26'b0, vecIdx}, 32'd35);
    @(negedge clk); secIrqIn = 32'h0010_0000;
    rd(3'd1, d);
    chk("R7 super -> bit4", d, 32'h0000_0010);
    chk("R10 super vec", {26'b0, vecIdx}, 32'd52);
  endtask

  task automatic t_secEdge();
    logic [31:0] d;
    doReset();
    @(negedge clk); secIrqIn[22] = 1'b1;
    @(negedge clk); secIrqIn[22] = 1'b0; secIrqIn[5] = 1'b1;
    rd(3'd5, d);
    chk("R8 edge + level", d, 32'h0040_0020);
    wr(3'd5, 32'hFFFF_FFFF);
    @(negedge clk); secIrqIn[5] = 1'b0;
    rd(3'd5, d);
    chk("R8 one keeps", d, 32'h0040_0000);
    wr(3'd5, ~32'h0040_0000);
    rd(3'd5, d);
    chk("R8 zero clears", d, 32'h0);
  endtask

  task automatic t_vector();
    doReset();
    wr(3'd0, 32'hFFFF_FFFF);
    @(negedge clk); priIrqIn = 32'h0200_0400; #1;
    chk("R9 vec 10", {26'b0, vecIdx}, 32'd10);
    @(negedge clk); priIrqIn = 32'h0200_0000; #1;
    chk("R9 vec 25", {26'b0, vecIdx}, 32'd25);
    @(negedge clk); priIrqIn = '0; secIrqIn[1] = 1'b1;
    wr(3'd4, 32'h0000_0002);
    @(negedge clk); priIrqIn[8] = 1'b1; #1;
    chk("R10 group below direct", {26'b0, vecIdx}, 32'd33);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    doReset();
    wr(3'd0, 32'h0000_0070);
    @(negedge clk); priIrqIn = 32'h0000_0070; #1;
    chk("R11 direct group quiet", {31'b0, irqOut}, 32'h0);
    rd(3'd1, d);
    chk("R11 status group zero", d, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d);
    chk("R11 status write ignored", d, 32'h0);
    chk("R11 irq still low", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_rdata();
    logic [31:0] d;
    doReset();
    wr(3'd0, 32'h0000_0123);
    @(negedge clk);
    busRd = 1'b1; busAddr = 3'd0; #1;
    chk("R12 old before edge", busRdata, 32'h0);
    @(negedge clk); busRd = 1'b0;
    chk("R12 new after edge", busRdata, 32'h0000_0123);
    wr(3'd0, 32'h0000_0456);
    @(negedge clk);
    chk("R12 held without read", busRdata, 32'h0000_0123);
    rd(3'd0, d);
    chk("R12 mask readback", d, 32'h0000_0456);
  endtask

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_clear();
    t_race();
    t_soft();
    t_groups();
    t_secEdge();
    t_vector();
    t_ignore();
    t_rdata();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(HALF * 2 * 100000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule